// File: doc/BRIEF.md
# Bus Even-Parity Generator and Checker

This block covers the parity side of a 32-bit multiplexed address/data bus agent. When the agent drives the address/data and command/byte-enable lines, the block produces the parity bit that goes with them. When the agent receives an address or a data phase, the block checks the parity bit that arrives on the following clock. Parity is even across all 37 bits: the 32 address/data bits, the 4 command/byte-enable bits and the parity bit itself.

A mismatch on a received data phase is signalled on the data-error line PERR#. A mismatch on a received address phase is signalled on the system-error line SERR#. Two enable bits from the command register gate these lines: the response-enable bit (command bit 6) and the system-error enable bit (command bit 8). The block also emits one-clock pulses that set the status-register error bits. Pads, tristate buffers and the rest of the bus protocol lie outside the block. The enables are sampled in the clock in which the parity bit for a phase is received.

Two small state machines drive the error lines. The data-error machine has four states. PERR_OFF means the line is released. PERR_GOOD drives it high after a clean checked phase. PERR_BAD drives it low after a bad phase. PERR_RESTORE drives it high for one clock after a low before the line is released. Transitions: any state goes to PERR_BAD or PERR_GOOD when a checked data phase completes with the response enable set. With no such check, PERR_BAD goes to PERR_RESTORE and every other state goes to PERR_OFF. The system-error machine has two states. It moves from SERR_IDLE to SERR_PULSE on an enabled address parity error, and it always leaves SERR_PULSE after one clock.

Top module: `bus_parity_unit`

## Requirements
- R1: In the clock after a cycle with drive_en_i high, par_o makes the count of ones over that cycle's ad_i, cbe_n_i and par_o even.
- R2: par_oe_o is high in exactly the clocks that follow a clock with drive_en_i high.
- R3: A received data phase (data_done_i=1, addr_phase_i=0, drive_en_i=0) whose 37-bit count is odd, using par_i from the next clock, drives perr_n_o low with perr_oe_o high for one clock, two clocks after the phase, when resp_en_i (command bit 6) is 1.
- R4: With resp_en_i set, every checked data phase drives PERR# two clocks later: high when parity is good, low when it is bad. Back-to-back data phases give back-to-back PERR# values.
- R5: After a clock with PERR# driven low, the next clock drives it high when no new data check lands there, and the clock after that releases it.
- R6: With resp_en_i clear, perr_oe_o stays low.
- R7: An address phase (addr_phase_i=1, drive_en_i=0) with a parity error drives serr_n_o low with serr_oe_o high for exactly one clock, two clocks after the phase, only when resp_en_i and serr_en_i are both 1. Otherwise serr_oe_o is 0 and serr_n_o is 1.
- R8: set_detected_o pulses for one clock, two clocks after every received address or data phase with a parity error, regardless of the enables.
- R9: set_signaled_o pulses in exactly the clocks in which SERR# is asserted.
- R10: A phase with drive_en_i high is never checked, even if addr_phase_i or data_done_i is also high.
- R11: When addr_phase_i and data_done_i are both high, the phase is checked as an address phase only.
- R12: After reset, par_oe_o, perr_oe_o, serr_oe_o, set_detected_o and set_signaled_o are 0, and perr_n_o and serr_n_o are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_i | input | 32 | Address/data bus value |
| cbe_n_i | input | 4 | Command/byte-enable value |
| par_i | input | 1 | Received parity bit (one clock behind the phase) |
| addr_phase_i | input | 1 | Address phase on the bus this clock |
| data_done_i | input | 1 | Data phase completed this clock |
| drive_en_i | input | 1 | Agent drives AD and C/BE# this clock |
| resp_en_i | input | 1 | Parity-error response enable (command bit 6) |
| serr_en_i | input | 1 | System-error enable (command bit 8) |
| par_o | output | 1 | Generated parity |
| par_oe_o | output | 1 | Output enable for par_o |
| perr_n_o | output | 1 | Data parity error, active low |
| perr_oe_o | output | 1 | Output enable for perr_n_o |
| serr_n_o | output | 1 | Address parity error, active low, open-drain style |
| serr_oe_o | output | 1 | Output enable for serr_n_o |
| set_detected_o | output | 1 | Pulse that sets the detected-parity-error status bit |
| set_signaled_o | output | 1 | Pulse that sets the signaled-system-error status bit |

## Verification
The bench goes after the pipeline timing first. A design that checked par_i in the same clock as the phase, or reported one clock early or late, would flag good phases and miss bad ones. Back-to-back bad data phases show whether PERR# holds low for two clocks and then restores high; a design that released the line straight away would leave it floating low. The enable combinations, driven phases with both qualifiers set, and a phase marked as both address and data check the gating and priority. A design that got these wrong would raise SERR# on one enable bit alone, check the agent's own cycles, or report one error on both lines.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_kind_t;

    typedef enum logic [1:0] {
        PERR_OFF     = 2'd0,
        PERR_GOOD    = 2'd1,
        PERR_BAD     = 2'd2,
        PERR_RESTORE = 2'd3
    } perr_state_t;

    typedef enum logic {
        SERR_IDLE  = 1'b0,
        SERR_PULSE = 1'b1
    } serr_state_t;

endpackage

// File: rtl/bpu_capture.sv
// Stage one: folds AD and C/BE# into a parity bit per byte lane, registers
// the generated parity and classifies the phase for the check stage.
module bpu_capture
    import bpu_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_n_i,
    input  logic            addr_phase_i,
    input  logic            data_done_i,
    input  logic            drive_en_i,
    output logic            par_o,
    output logic            par_oe_o,
    output logic            parity_q,
    output phase_kind_t     kind_q
);
    localparam int LANE_W = AD_W / BE_W;

    logic [BE_W-1:0] lane_par;
    logic            fold_par;
    phase_kind_t     kind_d;

    generate
        for (genvar g = 0; g < BE_W; g++) begin : g_lane
            assign lane_par[g] = (^ad_i[g*LANE_W +: LANE_W]) ^ cbe_n_i[g];
        end
    endgenerate

    assign fold_par = ^lane_par;

    always_comb begin
        if (drive_en_i)        kind_d = PH_NONE;
        else if (addr_phase_i) kind_d = PH_ADDR;
        else if (data_done_i)  kind_d = PH_DATA;
        else                   kind_d = PH_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            parity_q <= 1'b0;
            kind_q   <= PH_NONE;
            par_oe_o <= 1'b0;
        end else begin
            parity_q <= fold_par;
            kind_q   <= kind_d;
            par_oe_o <= drive_en_i;
        end
    end

    assign par_o = parity_q;

    p_par_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(drive_en_i) |-> ((^{$past(ad_i), $past(cbe_n_i), par_o}) == 1'b0));

    p_par_oe_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_oe_o) |-> $past(drive_en_i));

endmodule

// File: rtl/bpu_compare.sv
// Stage two: compares the stored parity with the parity bit received one
// clock after the phase and raises the check events.
module bpu_compare
    import bpu_pkg::*;
(
    input  phase_kind_t kind_q,
    input  logic        parity_q,
    input  logic        par_i,
    output logic        data_chk,
    output logic        data_err,
    output logic        addr_err
);
    logic mismatch;

    assign mismatch = parity_q ^ par_i;

    always_comb begin
        data_chk = 1'b0;
        data_err = 1'b0;
        addr_err = 1'b0;
        unique case (kind_q)
            PH_ADDR: addr_err = mismatch;
            PH_DATA: begin
                data_chk = 1'b1;
                data_err = mismatch;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bpu_perr_fsm.sv
// Data-error line driver: high or low per checked phase, one high clock of
// restore after a low, then released.
module bpu_perr_fsm
    import bpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chk_i,
    input  logic err_i,
    output logic perr_n_o,
    output logic perr_oe_o
);
    perr_state_t state_q, state_d;

    always_comb begin
        if (chk_i)                  state_d = err_i ? PERR_BAD : PERR_GOOD;
        else if (state_q == PERR_BAD) state_d = PERR_RESTORE;
        else                        state_d = PERR_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PERR_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PERR_OFF:     begin perr_oe_o = 1'b0; perr_n_o = 1'b1; end
            PERR_GOOD:    begin perr_oe_o = 1'b1; perr_n_o = 1'b1; end
            PERR_BAD:     begin perr_oe_o = 1'b1; perr_n_o = 1'b0; end
            PERR_RESTORE: begin perr_oe_o = 1'b1; perr_n_o = 1'b1; end
            default:      begin perr_oe_o = 1'b0; perr_n_o = 1'b1; end
        endcase
    end

    p_perr_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(perr_oe_o) && !$past(perr_n_o)) |-> perr_oe_o);

endmodule

// File: rtl/bpu_serr_fsm.sv
// System-error line driver: single-clock low pulse, otherwise undriven.
module bpu_serr_fsm
    import bpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic serr_n_o,
    output logic serr_oe_o,
    output logic signaled_o
);
    serr_state_t state_q, state_d;

    always_comb begin
        state_d = fire_i ? SERR_PULSE : SERR_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SERR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SERR_PULSE: begin serr_oe_o = 1'b1; serr_n_o = 1'b0; signaled_o = 1'b1; end
            default:    begin serr_oe_o = 1'b0; serr_n_o = 1'b1; signaled_o = 1'b0; end
        endcase
    end

    p_serr_open_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        serr_oe_o |-> !serr_n_o);

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
    import bpu_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_n_i,
    input  logic            par_i,
    input  logic            addr_phase_i,
    input  logic            data_done_i,
    input  logic            drive_en_i,
    input  logic            resp_en_i,
    input  logic            serr_en_i,
    output logic            par_o,
    output logic            par_oe_o,
    output logic            perr_n_o,
    output logic            perr_oe_o,
    output logic            serr_n_o,
    output logic            serr_oe_o,
    output logic            set_detected_o,
    output logic            set_signaled_o
);
    logic        parity_q;
    phase_kind_t kind_q;
    logic        data_chk, data_err, addr_err;

    bpu_capture #(.AD_W(AD_W), .BE_W(BE_W)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .ad_i         (ad_i),
        .cbe_n_i      (cbe_n_i),
        .addr_phase_i (addr_phase_i),
        .data_done_i  (data_done_i),
        .drive_en_i   (drive_en_i),
        .par_o        (par_o),
        .par_oe_o     (par_oe_o),
        .parity_q     (parity_q),
        .kind_q       (kind_q)
    );

    bpu_compare u_compare (
        .kind_q   (kind_q),
        .parity_q (parity_q),
        .par_i    (par_i),
        .data_chk (data_chk),
        .data_err (data_err),
        .addr_err (addr_err)
    );

    bpu_perr_fsm u_perr (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_i     (data_chk & resp_en_i),
        .err_i     (data_err),
        .perr_n_o  (perr_n_o),
        .perr_oe_o (perr_oe_o)
    );

    bpu_serr_fsm u_serr (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (addr_err & resp_en_i & serr_en_i),
        .serr_n_o   (serr_n_o),
        .serr_oe_o  (serr_oe_o),
        .signaled_o (set_signaled_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) set_detected_o <= 1'b0;
        else        set_detected_o <= data_err | addr_err;
    end

    p_perr_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe_o && !perr_n_o) |-> $past(resp_en_i));

    p_serr_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        serr_oe_o |-> ($past(resp_en_i) && $past(serr_en_i)));

    p_detect_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe_o && !perr_n_o) |-> set_detected_o);

    p_signaled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        serr_oe_o |-> set_signaled_o);

endmodule

// File: tb/test_bus_parity_unit.sv
module test_bus_parity_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic        par_in = 1'b0, addr_ph = 1'b0, data_dn = 1'b0, drv = 1'b0;
    logic        resp_en = 1'b1, serr_en = 1'b1;
    logic        par, par_oe, perr_n, perr_oe, serr_n, serr_oe, det, sig;
    int          errors = 0, checks = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    bus_parity_unit i_bus_parity_unit (
        .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe), .par_i(par_in),
        .addr_phase_i(addr_ph), .data_done_i(data_dn), .drive_en_i(drv),
        .resp_en_i(resp_en), .serr_en_i(serr_en),
        .par_o(par), .par_oe_o(par_oe), .perr_n_o(perr_n), .perr_oe_o(perr_oe),
        .serr_n_o(serr_n), .serr_oe_o(serr_oe),
        .set_detected_o(det), .set_signaled_o(sig)
    );

    // {ad, cbe, kind(0 idle,1 addr,2 data,3 driven), flip parity}
    localparam int NV = 10;
    localparam logic [38:0] VEC [NV] = '{
        {32'h0000_0000, 4'h0, 2'd2, 1'b0},
        {32'hFFFF_FFFF, 4'hF, 2'd2, 1'b1},
        {32'h1234_5678, 4'h6, 2'd1, 1'b0},
        {32'h8000_0000, 4'h7, 2'd1, 1'b1},
        {32'hDEAD_BEEF, 4'h0, 2'd3, 1'b1},
        {32'h0000_0001, 4'h0, 2'd2, 1'b1},
        {32'hA5A5_A5A5, 4'hC, 2'd3, 1'b0},
        {32'h0F0F_0F0F, 4'h3, 2'd0, 1'b1},
        {32'h7FFF_FFFF, 4'hE, 2'd2, 1'b0},
        {32'h0001_0000, 4'h1, 2'd1, 1'b0}
    };

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic phase(input logic [31:0] a, input logic [3:0] c,
                         input logic ap, input logic dd, input logic dv);
        ad = a; cbe = c; addr_ph = ap; data_dn = dd; drv = dv;
    endtask

    task automatic idle();
        addr_ph = 1'b0; data_dn = 1'b0; drv = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(par_oe, 1'b0, "R12 par_oe");
        chk(perr_oe, 1'b0, "R12 perr_oe");
        chk(perr_n, 1'b1, "R12 perr_n");
        chk(serr_oe, 1'b0, "R12 serr_oe");
        chk(serr_n, 1'b1, "R12 serr_n");
        chk(det, 1'b0, "R12 detected");
        chk(sig, 1'b0, "R12 signaled");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] va; logic [3:0] vc; logic [1:0] vk; logic vf;
            logic gp, bad, chkd, serr_exp;
            {va, vc, vk, vf} = VEC[i];
            gp = ^{va, vc};
            bad = vf && (vk == 2'd1 || vk == 2'd2);
            chkd = (vk == 2'd2);
            serr_exp = (vk == 2'd1) && vf;
            @(negedge clk);
            phase(va, vc, vk == 2'd1, vk == 2'd2 || vk == 2'd3, vk == 2'd3);
            @(negedge clk);
            chk(par_oe, vk == 2'd3, "R2 par_oe after phase");
            if (vk == 2'd3) chk(par, gp, "R1 generated parity");
            idle();
            par_in = gp ^ vf;
            @(negedge clk);
            chk(par_oe, 1'b0, "R2 par_oe released");
            chk(perr_oe, chkd, "R4/R10 perr_oe");
            chk(perr_n, !(chkd && vf), "R3 perr_n");
            chk(serr_oe, serr_exp, "R7/R10 serr_oe");
            chk(serr_n, !serr_exp, "R7 serr_n");
            chk(det, bad, "R8/R10 detected");
            chk(sig, serr_exp, "R9 signaled");
            @(negedge clk);
            chk(perr_oe, chkd && vf, "R5 restore drive");
            chk(perr_n, 1'b1, "R5 restore high");
            chk(serr_oe, 1'b0, "R7 serr single clock");
            chk(det, 1'b0, "R8 detected single clock");
        end

        // R6/R8: bad data phase, response disabled
        resp_en = 1'b0; serr_en = 1'b1;
        @(negedge clk); phase(32'h0000_0003, 4'h0, 1'b0, 1'b1, 1'b0);
        @(negedge clk); idle(); par_in = 1'b1;
        @(negedge clk);
        chk(perr_oe, 1'b0, "R6 perr_oe off with response disabled");
        chk(det, 1'b1, "R8 detected with response disabled");
        @(negedge clk);
        chk(perr_oe, 1'b0, "R6 perr_oe stays off");

        // R7: bad address phase, only serr enable
        @(negedge clk); phase(32'h0000_0000, 4'h1, 1'b1, 1'b0, 1'b0);
        @(negedge clk); idle(); par_in = 1'b0;
        @(negedge clk);
        chk(serr_oe, 1'b0, "R7 serr needs bit 6");
        chk(det, 1'b1, "R8 detected address, enables off");

        // R7: bad address phase, only response enable
        resp_en = 1'b1; serr_en = 1'b0;
        @(negedge clk); phase(32'h0000_0000, 4'h1, 1'b1, 1'b0, 1'b0);
        @(negedge clk); idle(); par_in = 1'b0;
        @(negedge clk);
        chk(serr_oe, 1'b0, "R7 serr needs bit 8");
        chk(serr_n, 1'b1, "R7 serr_n high when gated");
        chk(sig, 1'b0, "R9 no signaled when gated");
        chk(perr_oe, 1'b0, "R7 address error not on perr");
        @(negedge clk);

        // R11: address and data qualifiers together, bad parity
        serr_en = 1'b1;
        @(negedge clk); phase(32'h0000_00FF, 4'h0, 1'b1, 1'b1, 1'b0);
        @(negedge clk); idle(); par_in = 1'b1;
        @(negedge clk);
        chk(serr_oe, 1'b1, "R11 treated as address");
        chk(perr_oe, 1'b0, "R11 no data check");
        @(negedge clk);

        // R4/R5: bad, bad, good data phases back to back
        @(negedge clk); phase(32'h0000_0001, 4'h0, 1'b0, 1'b1, 1'b0);
        @(negedge clk); par_in = 1'b0; phase(32'h0000_0003, 4'h1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk(perr_oe, 1'b1, "R4 first bad driven");
        chk(perr_n, 1'b0, "R3 first bad low");
        par_in = 1'b0; phase(32'h0000_0007, 4'h0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk(perr_n, 1'b0, "R4 second bad low");
        chk(det, 1'b1, "R8 second bad detected");
        idle(); par_in = 1'b1;
        @(negedge clk);
        chk(perr_oe, 1'b1, "R4 good phase driven");
        chk(perr_n, 1'b1, "R4 good phase high");
        chk(det, 1'b0, "R8 good phase no detect");
        @(negedge clk);
        chk(perr_oe, 1'b0, "R5 released after good");

        summary();
    end
endmodule